// File: doc/BRIEF.md
# Triple Watchdog Timer Peripheral

This peripheral holds three independent watchdog timers behind a small word-addressed register bus. Each timer is a 16-bit down-counter with its own limit register, status byte and tick prescaler. Software arms a timer by writing its limit, keeps it alive by reading its counter, and must do so before the count runs out. The expiry action depends on the timer. Timer 0 raises a level interrupt. Timer 1 issues a CPU-only reset pulse. Timer 2 issues a pulse that resets the whole board.

One counter step is 100 ms. The parameter `TICK_DIV` gives the number of system clocks in one step. Each timer restarts its prescaler phase when it is armed or pinged, so the interval is exact. A shared mask byte suppresses the expiry action of each timer. Masking does not stop the countdown. Sixteen-bit values travel on the bus with their two bytes swapped.

Top module: `wdt_trio`

## Requirements
- R1: After reset, every counter and every limit register holds 1, every status byte and the mask byte read 0, and `irq_o`, `cpu_rst_o` and `board_rst_o` are low.
- R2: Writing the limit register (offset 4 of a timer group) loads the counter and the limit with the written value. The write sets running and clears expired. Reading the limit returns the stored value and changes nothing.
- R3: A running timer decrements once every `TICK_DIV` clocks, counted from its last limit write or ping. A limit L ≥ 1 expires exactly L·`TICK_DIV` clocks after the write. A limit of 0 expires after one step.
- R4: On expiry the count stays at 0, the running bit clears and the expired bit sets. The expired bit stays set until the next limit write.
- R5: Reading the counter register (offset 0) returns the current count. The read also reloads the counter from the limit and restarts the step phase.
- R6: The status byte (offset 8) reads bit 0 = running and bit 1 = expired, with bits 15..2 zero. Writes to the status byte are ignored.
- R7: The mask byte at 0x30 uses bit k to mask timer k. Bits 15..3 read zero. A masked timer keeps counting and reaches expiry, but its action output stays low.
- R8: `irq_o` is high exactly while timer 0 is expired and mask bit 0 is clear.
- R9: When timer 1 (or timer 2) expires with its mask bit clear, `cpu_rst_o` (or `board_rst_o`) goes high from that expiry edge for `RST_PULSE` clocks. Only the expiring timer's output pulses.
- R10: Timer k's registers sit at byte offsets 16k + {0, 4, 8}. The byte at 0x34 reads the three expired flags in bits 2..0. Any other or misaligned address reads 0. A 16-bit value v appears on the bus as {v[7:0], v[15:8]}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Byte address |
| wdata_i | input | 16 | Write data (16-bit values byte-swapped) |
| rdata_o | output | 16 | Read data, registered |
| irq_o | output | 1 | Timer 0 expiry interrupt, level |
| cpu_rst_o | output | 1 | Timer 1 CPU reset pulse |
| board_rst_o | output | 1 | Timer 2 board reset pulse |

## Verification
Read data is registered, so it is valid at the falling edge that follows the clock edge which sampled the read. The side effects of an access, such as a reload, a start, a cleared expired bit or a mask change, take hold at that same edge. Expiry and a reset pulse's rising edge fall exactly L·`TICK_DIV` edges after the arming or pinging edge. A reset pulse falls `RST_PULSE` edges after it rises. The interrupt follows the expired and mask state with no added delay. The bench advances one cycle per bus access and counts clock edges from the access edge. It samples outputs at falling edges, on the cycle just before and the cycle just after each due edge.

// File: rtl/wdt_trio_pkg.sv
package wdt_trio_pkg;
  localparam int NUM_TMR = 3;
  localparam int CNT_W   = 16;
  localparam int ADDR_W  = 6;

  // register slot inside a timer group, addr[3:2]
  localparam logic [1:0] SLOT_CNT  = 2'd0;
  localparam logic [1:0] SLOT_LIM  = 2'd1;
  localparam logic [1:0] SLOT_STAT = 2'd2;
  // slots inside the shared group (addr[5:4] == 3)
  localparam logic [1:0] SLOT_MASK = 2'd0;
  localparam logic [1:0] SLOT_DEV  = 2'd1;
  localparam logic [1:0] GRP_SHARED = 2'd3;

  typedef enum logic [1:0] {
    ACT_IRQ,
    ACT_CPU_RST,
    ACT_BOARD_RST
  } act_e;

  function automatic act_e act_of(int idx);
    case (idx)
      0:       return ACT_IRQ;
      1:       return ACT_CPU_RST;
      default: return ACT_BOARD_RST;
    endcase
  endfunction

  function automatic logic [15:0] lane_swap(logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction
endpackage

// File: rtl/wdt_step_gen.sv
module wdt_step_gen #(
  parameter int TICK_DIV = 12_500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre_q;

  assign tick_o = en_i && !clr_i && (pre_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    pre_q <= '0;
    else if (clr_i || !en_i)        pre_q <= '0;
    else if (pre_q == LAST)         pre_q <= '0;
    else                            pre_q <= pre_q + PW'(1);
  end

  AST_PRE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= LAST);  // R3
  AST_PRE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> pre_q == '0);  // R5
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_trio_pkg::*;
#(
  parameter int TICK_DIV = 12_500_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lim_wr_i,
  input  logic [CNT_W-1:0] lim_wdata_i,
  input  logic             ping_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] lim_o,
  output logic             run_o,
  output logic             exp_o,
  output logic             exp_evt_o
);
  logic [CNT_W-1:0] cnt_q, lim_q;
  logic             run_q, exp_q, tick;

  wdt_step_gen #(.TICK_DIV(TICK_DIV)) u_step (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (run_q),
    .clr_i  (lim_wr_i | ping_i),
    .tick_o (tick)
  );

  // a count of 0 or 1 at a step edge ends the countdown
  assign exp_evt_o = run_q && tick && !lim_wr_i && !ping_i && (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CNT_W'(1);
      lim_q <= CNT_W'(1);
      run_q <= 1'b0;
      exp_q <= 1'b0;
    end else if (lim_wr_i) begin
      cnt_q <= lim_wdata_i;
      lim_q <= lim_wdata_i;
      run_q <= 1'b1;
      exp_q <= 1'b0;
    end else if (ping_i) begin
      cnt_q <= lim_q;
    end else if (exp_evt_o) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      exp_q <= 1'b1;
    end else if (run_q && tick) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;
  assign lim_o = lim_q;
  assign run_o = run_q;
  assign exp_o = exp_q;

  AST_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lim_wr_i |=> run_q && !exp_q && cnt_q == $past(lim_wdata_i));  // R2
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lim_wr_i && !ping_i && !tick |=> $stable(cnt_q));  // R3
  AST_EXP_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(exp_q && run_q));  // R4
  AST_EXP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_q && !lim_wr_i |=> exp_q);  // R4
  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ping_i && !lim_wr_i |=> cnt_q == $past(lim_q));  // R5
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int RST_PULSE = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int PW = $clog2(RST_PULSE + 1);

  logic [PW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             left_q <= '0;
    else if (trig_i)         left_q <= PW'(RST_PULSE);
    else if (left_q != '0)   left_q <= left_q - PW'(1);
  end

  assign pulse_o = (left_q != '0);

  AST_PULSE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> pulse_o);  // R9
  AST_PULSE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left_q <= PW'(RST_PULSE));  // R9
endmodule

// File: rtl/wdt_trio.sv
module wdt_trio
  import wdt_trio_pkg::*;
#(
  parameter int TICK_DIV  = 12_500_000,
  parameter int RST_PULSE = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  output logic              irq_o,
  output logic              cpu_rst_o,
  output logic              board_rst_o
);
  logic [1:0] grp, slot;
  logic       hit, rd, wr;

  assign grp  = addr_i[5:4];
  assign slot = addr_i[3:2];
  assign hit  = req_i && (addr_i[1:0] == 2'b00);
  assign rd   = hit && !we_i;
  assign wr   = hit && we_i;

  logic [NUM_TMR-1:0] lim_wr, ping, run, expd, evt, act;
  logic [CNT_W-1:0]   cnt [NUM_TMR];
  logic [CNT_W-1:0]   lim [NUM_TMR];
  logic [NUM_TMR-1:0] mask_q;
  logic               mask_wr;

  assign mask_wr = wr && grp == GRP_SHARED && slot == SLOT_MASK;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    assign lim_wr[i] = wr && grp == 2'(i) && slot == SLOT_LIM;
    assign ping[i]   = rd && grp == 2'(i) && slot == SLOT_CNT;

    wdt_timer #(.TICK_DIV(TICK_DIV)) u_tmr (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .lim_wr_i    (lim_wr[i]),
      .lim_wdata_i (lane_swap(wdata_i)),
      .ping_i      (ping[i]),
      .cnt_o       (cnt[i]),
      .lim_o       (lim[i]),
      .run_o       (run[i]),
      .exp_o       (expd[i]),
      .exp_evt_o   (evt[i])
    );

    if (act_of(i) == ACT_IRQ) begin : g_lvl
      assign act[i] = expd[i] & ~mask_q[i];
    end else begin : g_pls
      wdt_pulse #(.RST_PULSE(RST_PULSE)) u_pls (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .trig_i  (evt[i] & ~mask_q[i]),
        .pulse_o (act[i])
      );
    end
  end

  assign irq_o       = act[0];
  assign cpu_rst_o   = act[1];
  assign board_rst_o = act[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (mask_wr) mask_q <= wdata_i[NUM_TMR-1:0];
  end

  logic [15:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (grp == GRP_SHARED) begin
      case (slot)
        SLOT_MASK: rd_val = 16'(mask_q);
        SLOT_DEV:  rd_val = 16'(expd);
        default:   rd_val = '0;
      endcase
    end else begin
      for (int k = 0; k < NUM_TMR; k++) begin
        if (grp == 2'(k)) begin
          case (slot)
            SLOT_CNT:  rd_val = lane_swap(cnt[k]);
            SLOT_LIM:  rd_val = lane_swap(lim[k]);
            SLOT_STAT: rd_val = {14'b0, expd[k], run[k]};
            default:   rd_val = '0;
          endcase
        end
      end
    end
  end

  logic [15:0] rdata_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (req_i && !we_i) rdata_q <= hit ? rd_val : 16'h0000;
  end
  assign rdata_o = rdata_q;

  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_wr |=> $stable(mask_q));  // R7
  AST_CPU_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_rst_o) |-> $past(evt[1] && !mask_q[1]));  // R9
  AST_BOARD_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(board_rst_o) |-> $past(evt[2] && !mask_q[2]));  // R9
  AST_IRQ_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> expd[0]);  // R8
endmodule

// File: tb/wdt_trio_bench.sv
module wdt_trio_bench;
  localparam int DIV = 8;
  localparam int PLS = 3;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq, cpu_rst, board_rst;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wdt_trio #(.TICK_DIV(DIV), .RST_PULSE(PLS)) u_wdt_trio (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .cpu_rst_o(cpu_rst),
    .board_rst_o(board_rst)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // one access per cycle; entered and left at a falling edge
  task automatic op(bit w, logic [5:0] a, logic [15:0] d);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [5:0] a, logic [15:0] exp);
    op(1'b0, a, 16'h0);
    chk(tag, rdata, exp);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; req = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  // {we, addr, wdata, expected}
  localparam int NV = 15;
  localparam logic [38:0] VEC [NV] = '{
    {1'b0, 6'h00, 16'h0000, 16'h0100},  // R1 R10 counter 0 reset value, swapped
    {1'b0, 6'h14, 16'h0000, 16'h0100},  // R1 limit 1
    {1'b0, 6'h28, 16'h0000, 16'h0000},  // R1 status 2
    {1'b0, 6'h30, 16'h0000, 16'h0000},  // R1 mask
    {1'b0, 6'h34, 16'h0000, 16'h0000},  // R10 expired flags
    {1'b1, 6'h04, 16'h3412, 16'h0000},  // R2 arm timer 0 with 0x1234
    {1'b0, 6'h04, 16'h0000, 16'h3412},  // R2 limit readback
    {1'b0, 6'h08, 16'h0000, 16'h0001},  // R6 running
    {1'b1, 6'h30, 16'h00ff, 16'h0000},
    {1'b0, 6'h30, 16'h0000, 16'h0007},  // R7 upper mask bits zero
    {1'b1, 6'h30, 16'h0000, 16'h0000},
    {1'b1, 6'h18, 16'h00ff, 16'h0000},  // R6 status write ignored
    {1'b0, 6'h18, 16'h0000, 16'h0000},  // R6
    {1'b0, 6'h00, 16'h0000, 16'h3412},  // R5 count before first step
    {1'b0, 6'h3c, 16'h0000, 16'h0000}   // R10 unmapped
  };

  initial begin
    do_reset();
    chk("R1 irq", 16'(irq), 16'h0);
    chk("R1 cpu_rst", 16'(cpu_rst), 16'h0);
    chk("R1 board_rst", 16'(board_rst), 16'h0);

    for (int v = 0; v < NV; v++) begin
      op(VEC[v][38], VEC[v][37:32], VEC[v][31:16]);
      if (!VEC[v][38]) chk($sformatf("R1-R10 table row %0d", v), rdata, VEC[v][15:0]);
    end

    // timer 0 expiry, interrupt level, sticky state
    do_reset();
    op(1'b1, 6'h04, 16'h0300);
    wait_cyc(3*DIV - 1);
    chk("R3 irq before expiry", 16'(irq), 16'h0);
    wait_cyc(1);
    chk("R3 R8 irq at expiry", 16'(irq), 16'h1);
    rd_chk("R4 status expired", 6'h08, 16'h0002);
    rd_chk("R4 count held zero", 6'h00, 16'h0000);
    chk("R4 irq sticky", 16'(irq), 16'h1);
    op(1'b1, 6'h04, 16'h0200);
    chk("R2 R8 irq cleared by arm", 16'(irq), 16'h0);
    rd_chk("R2 status running again", 6'h08, 16'h0001);

    // timer 1 ping and CPU reset pulse
    do_reset();
    op(1'b1, 6'h14, 16'h0200);
    wait_cyc(12);
    rd_chk("R5 ping returns count 1", 6'h10, 16'h0100);
    wait_cyc(2*DIV - 1);
    chk("R5 no expiry before reload interval", 16'(cpu_rst), 16'h0);
    wait_cyc(1);
    chk("R9 cpu_rst rises", 16'(cpu_rst), 16'h1);
    chk("R9 board_rst quiet", 16'(board_rst), 16'h0);
    chk("R9 irq quiet", 16'(irq), 16'h0);
    wait_cyc(PLS - 1);
    chk("R9 cpu_rst last cycle", 16'(cpu_rst), 16'h1);
    wait_cyc(1);
    chk("R9 cpu_rst ends", 16'(cpu_rst), 16'h0);

    // masked timer 2 keeps counting
    do_reset();
    op(1'b1, 6'h30, 16'h0004);
    op(1'b1, 6'h24, 16'h0100);
    rd_chk("R7 masked timer runs", 6'h28, 16'h0001);
    wait_cyc(DIV - 1);
    chk("R7 board_rst masked", 16'(board_rst), 16'h0);
    rd_chk("R7 masked timer expired", 6'h28, 16'h0002);
    rd_chk("R10 device expired flags", 6'h34, 16'h0004);
    chk("R7 board_rst stays low", 16'(board_rst), 16'h0);

    // interrupt gated by mask level
    op(1'b1, 6'h30, 16'h0001);
    op(1'b1, 6'h04, 16'h0100);
    wait_cyc(DIV);
    chk("R8 irq masked", 16'(irq), 16'h0);
    op(1'b1, 6'h30, 16'h0000);
    chk("R8 irq after unmask", 16'(irq), 16'h1);

    // zero limit expires after one step
    do_reset();
    op(1'b1, 6'h04, 16'h0000);
    wait_cyc(DIV - 1);
    chk("R3 zero limit early", 16'(irq), 16'h0);
    wait_cyc(1);
    chk("R3 zero limit expiry", 16'(irq), 16'h1);

    // misaligned read returns zero
    rd_chk("R10 misaligned", 6'h05, 16'h0000);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule